// File: doc/BRIEF.md
# Double-Buffered Byte-Lane Converter Front End

This block sits between a host's parallel bus and a 16-bit digital-to-analog converter core. The host can write a full 16-bit word in one strobe, or write the lower and upper bytes separately with two byte selects. Each byte lands in its own input register. A separate load strobe copies the pair into the output register, and that register holds the code the converter core sees. Because the input registers and the output register are separate, the host can stage a new value piece by piece. The output then changes once, at a moment the system chooses.

All host strobes are active low and are treated as asynchronous. Each one passes through a two-stage synchronizer into the system clock. The data bus passes through an equal number of stages, so each strobe stays aligned with the data it qualifies. The clear input empties every register as soon as it goes low. Its release is synchronized to the clock. A synchronous active-low reset plays the part of power-on reset. Next to the code, a change flag marks each cycle in which the output code has just taken a new value.

Top module: `dac_byte_front`

## Requirements
- R1: After a clock edge with `rst_n` low, `code` is 0x0000 and `code_upd` is 0.
- R2: In a cycle where the synchronized `wr_n` and `sel_lo_n` are both low, the lower input register takes `din[7:0]` and the upper register keeps its value.
- R3: In a cycle where the synchronized `wr_n` and `sel_hi_n` are both low, the upper input register takes `din[15:8]` and the lower register keeps its value.
- R4: With both selects low during one write, both input registers load in the same cycle, so the output shows the full word `din`.
- R5: A write strobe with no select low, or a select low with no write strobe, leaves both input registers unchanged.
- R6: While the synchronized `load_n` is low, the output register copies {upper, lower} on every clock, so an input-register change reaches `code` one cycle later.
- R7: While `load_n` is high, `code` holds its value, whatever writes occur.
- R8: `clr_n` low forces `code` and both input registers to zero at once, without waiting for a clock. The clear overrides writes and loads. Its effect lasts for two clock edges after `clr_n` rises.
- R9: With `load_n` held low, a write applied at the ports changes `code` on the fourth rising edge after it is applied: two synchronizer stages, the input register, and then the output register.
- R10: If `din` changes while the write and select stay low, the value held is the one present in the last cycle before the strobe rises.
- R11: `code_upd` is 1 for exactly the one cycle after `code` takes a new value, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| wr_n | input | 1 | Active-low write strobe from the host |
| sel_lo_n | input | 1 | Active-low select for the lower byte |
| sel_hi_n | input | 1 | Active-low select for the upper byte |
| load_n | input | 1 | Active-low transfer strobe, level-sensitive |
| clr_n | input | 1 | Active-low clear, asynchronous assertion |
| din | input | 16 | Host data bus |
| code | output | 16 | Output register, the code for the converter core |
| code_upd | output | 1 | High for one cycle after `code` changes |

## Verification
A wrong value in an input register stays hidden while the load strobe is high. It shows on `code` one cycle after the synchronized load strobe goes low, and with that strobe held low it shows on the edge that follows the bad capture. A fault in the synchronizer depth or the data alignment shows up in two ways: the code moves on the wrong edge of the four-edge latency, or the bench catches a neighbouring `din` value when the data changes under a held strobe. A faulty clear shows as a nonzero `code` in the very cycle `clr_n` falls, or as a write that gets through in the two cycles after release.

// File: rtl/dbf_pkg.sv
// Package: shared sizes and types for the byte-lane converter front end.
// Assumes two byte lanes form one output word.
package dbf_pkg;
    parameter int unsigned LANE_W  = 8;
    parameter int unsigned LANES   = 2;
    parameter int unsigned WORD_W  = LANE_W * LANES;
    parameter int unsigned SYNC_N  = 2;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dbf_sync_stages.sv
// Module: multi-bit shift pipeline of DEPTH flops, used to synchronize the
// host strobes and to delay the data bus by the same amount.
// Assumes DEPTH >= 1 and that each bit is sampled independently.
module dbf_sync_stages #(
    parameter int unsigned W       = 4,
    parameter int unsigned DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= RST_VAL;
                else        stage[0] <= din;
            end
        end else begin : g_next
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= RST_VAL;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/dbf_clr_sync.sv
// Module: clear conditioner. It asserts hold_n low as soon as clr_n falls
// and releases it after DEPTH rising edges with clr_n high.
// Assumes DEPTH >= 2. Reset also holds the clear asserted.
module dbf_clr_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic hold_n
);
    logic [DEPTH-1:0] sh;

    // Shift ones in after release; empty at once on clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      sh <= '0;
        else if (!rst_n) sh <= '0;
        else             sh <= {sh[DEPTH-2:0], 1'b1};
    end

    assign hold_n = sh[DEPTH-1];
endmodule

// File: rtl/dbf_lane_reg.sv
// Module: one byte-lane input register. It captures d on every cycle that
// we is high and is emptied without waiting for a clock while hold_n is low.
// Assumes we and d are already in the clk domain.
module dbf_lane_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the lane data; clear has priority over everything else.
    always_ff @(posedge clk or negedge hold_n) begin
        if (!hold_n)     q <= '0;
        else if (!rst_n) q <= '0;
        else if (we)     q <= d;
    end
endmodule

// File: rtl/dac_byte_front.sv
// Module: double-buffered byte-lane front end for a 16-bit converter.
// Host strobes and data pass through SYNC_N stages. Byte lanes load while
// write and their select are low. The output register follows the lanes
// while load is low. Clear empties everything without waiting for a clock.
// Assumes the host holds each strobe low for at least SYNC_N+1 clocks.
module dac_byte_front #(
    parameter int unsigned LANE_W = dbf_pkg::LANE_W,
    parameter int unsigned SYNC_N = dbf_pkg::SYNC_N,
    localparam int unsigned LANES  = dbf_pkg::LANES,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi_n,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] code,
    output logic              code_upd
);
    localparam int unsigned STB_W = 2 + LANES;

    logic [STB_W-1:0]  stb_s;
    logic              wr_s, ld_s, sel_lo_s, sel_hi_s;
    logic [LANES-1:0]  sel_s;
    logic [WORD_W-1:0] d_s;
    logic              clr_hold_n;
    logic [LANE_W-1:0] lane_q [LANES];
    logic [LANE_W-1:0] lo_q, hi_q;
    logic [WORD_W-1:0] code_q, last_q;

    dbf_sync_stages #(.W(STB_W), .DEPTH(SYNC_N), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
        .clk(clk), .rst_n(rst_n),
        .din({load_n, sel_hi_n, sel_lo_n, wr_n}),
        .dout(stb_s)
    );

    dbf_sync_stages #(.W(WORD_W), .DEPTH(SYNC_N), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(d_s)
    );

    dbf_clr_sync #(.DEPTH(SYNC_N)) u_clr (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .hold_n(clr_hold_n)
    );

    assign wr_s     = stb_s[0];
    assign sel_lo_s = stb_s[1];
    assign sel_hi_s = stb_s[2];
    assign ld_s     = stb_s[STB_W-1];
    assign sel_s    = {sel_hi_s, sel_lo_s};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dbf_lane_reg #(.W(LANE_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .hold_n(clr_hold_n),
            .we(!wr_s && !sel_s[l]),
            .d(d_s[l*LANE_W +: LANE_W]),
            .q(lane_q[l])
        );
    end

    assign lo_q = lane_q[0];
    assign hi_q = lane_q[LANES-1];

    // Output register: transparent to the lanes while load is low.
    always_ff @(posedge clk or negedge clr_hold_n) begin
        if (!clr_hold_n) code_q <= '0;
        else if (!rst_n) code_q <= '0;
        else if (!ld_s)  code_q <= {hi_q, lo_q};
    end

    // Remember the previous code to mark changes.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= code_q;
    end

    assign code     = code_q;
    assign code_upd = (code_q != last_q);
endmodule

// File: rtl/dac_byte_front_chk.sv
// Module: property checker for dac_byte_front, attached by bind.
// It watches the ports and the boundaries between the synchronizers,
// the lane registers and the output register.
module dac_byte_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_n,
    input logic [15:0] code,
    input logic        code_upd,
    input logic        wr_s,
    input logic        sel_lo_s,
    input logic        sel_hi_s,
    input logic        ld_s,
    input logic        clr_hold_n,
    input logic [15:0] d_s,
    input logic [7:0]  lo_q,
    input logic [7:0]  hi_q
);
    logic [1:0] armed;

    // Count cycles since reset so that history-based checks start valid.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed <= '0;
        else if (armed != 2'd3) armed <= armed + 2'd1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!clr_n)
        !rst_n |=> (code == 16'h0 && !code_upd));

    assert_lane_lo_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_hold_n && !wr_s && !sel_lo_s) |=> lo_q == $past(d_s[7:0]));

    assert_lane_hi_R3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_hold_n && !wr_s && !sel_hi_s) |=> hi_q == $past(d_s[15:8]));

    assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_hold_n && wr_s) |=> ($stable(lo_q) && $stable(hi_q)));

    assert_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_hold_n && !ld_s) |=> code == $past({hi_q, lo_q}));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (clr_hold_n && ld_s) |=> $stable(code));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code == 16'h0 && lo_q == 8'h0 && hi_q == 8'h0));

    assert_flag_R11: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (armed == 2'd3 && code != $past(code)) |-> code_upd);
endmodule

bind dac_byte_front dac_byte_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .code(code), .code_upd(code_upd),
    .wr_s(wr_s), .sel_lo_s(sel_lo_s), .sel_hi_s(sel_hi_s), .ld_s(ld_s),
    .clr_hold_n(clr_hold_n), .d_s(d_s), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/dac_byte_front_bench.sv
// Bench: drives the host strobes on falling edges. A behavioural model
// advances on rising edges, and the outputs are compared on every falling edge.
module dac_byte_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1, sel_lo_n = 1'b1, sel_hi_n = 1'b1, load_n = 1'b1, clr_n = 1'b1;
    logic [15:0] din = 16'h0;
    logic [15:0] code;
    logic        code_upd;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string tag = "R1";

    // Model state: strobe history oldest-first, {load, hi, lo, wr} per entry.
    logic [3:0]  m_stb [$];
    logic [15:0] m_dat [$];
    int          m_clr_cnt = 0;
    logic [7:0]  m_lo = 8'h0, m_hi = 8'h0;
    logic [15:0] m_out = 16'h0, m_last = 16'h0;

    always #2.5 clk = ~clk;

    dac_byte_front u_dac_byte_front (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n),
        .load_n(load_n), .clr_n(clr_n), .din(din), .code(code), .code_upd(code_upd)
    );

    task automatic model_edge();
        logic [3:0]  s;
        logic [15:0] d;
        logic [7:0]  nlo, nhi;
        logic [15:0] nout;
        if (!rst_n) begin
            m_stb = '{4'hF, 4'hF}; m_dat = '{16'h0, 16'h0};
            m_clr_cnt = 0; m_lo = 0; m_hi = 0; m_out = 0; m_last = 0;
            return;
        end
        s = m_stb[0]; d = m_dat[0];
        m_last = m_out;
        nlo = m_lo; nhi = m_hi; nout = m_out;
        if (m_clr_cnt < 2) begin
            nlo = 0; nhi = 0; nout = 0;
        end else begin
            if (!s[0] && !s[1]) nlo = d[7:0];
            if (!s[0] && !s[2]) nhi = d[15:8];
            if (!s[3])          nout = {m_hi, m_lo};
        end
        m_lo = nlo; m_hi = nhi; m_out = nout;
        void'(m_stb.pop_front()); m_stb.push_back({load_n, sel_hi_n, sel_lo_n, wr_n});
        void'(m_dat.pop_front()); m_dat.push_back(din);
        if (!clr_n) m_clr_cnt = 0;
        else if (m_clr_cnt < 2) m_clr_cnt++;
    endtask

    task automatic compare();
        vectors++;
        if (code !== m_out || code_upd !== (m_out != m_last)) begin
            miscompares++;
            $display("FAIL %s: code=%h upd=%b expected code=%h upd=%b",
                     tag, code, code_upd, m_out, (m_out != m_last));
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic expect_code(string t, logic [15:0] v);
        vectors++;
        if (code !== v) begin
            miscompares++;
            $display("FAIL %s: code=%h expected %h", t, code, v);
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0; cyc(1); load_n = 1'b1; cyc(4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                miscompares++;
                $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        m_stb = '{4'hF, 4'hF}; m_dat = '{16'h0, 16'h0};
        @(negedge clk);
        tag = "R1"; cyc(2);
        rst_n = 1'b1;
        cyc(3);
        expect_code("R1", 16'h0000);

        // R2 and R7: lower byte written with load high; code must hold.
        tag = "R2"; din = 16'hA55A; sel_lo_n = 0; wr_n = 0; cyc(2);
        wr_n = 1; sel_lo_n = 1; cyc(4);
        expect_code("R7", 16'h0000);
        pulse_load();
        expect_code("R2", 16'h005A);

        // R3: upper byte only.
        tag = "R3"; din = 16'h3CC3; sel_hi_n = 0; wr_n = 0; cyc(2);
        wr_n = 1; sel_hi_n = 1; cyc(3);
        pulse_load();
        expect_code("R3", 16'h3C5A);

        // R4: both selects together load the whole word.
        tag = "R4"; din = 16'h1234; sel_hi_n = 0; sel_lo_n = 0; wr_n = 0; cyc(2);
        wr_n = 1; sel_hi_n = 1; sel_lo_n = 1; cyc(3);
        pulse_load();
        expect_code("R4", 16'h1234);

        // R5: write without select, then selects without write.
        tag = "R5"; din = 16'hFFFF; wr_n = 0; cyc(3);
        wr_n = 1; sel_hi_n = 0; sel_lo_n = 0; cyc(3);
        sel_hi_n = 1; sel_lo_n = 1; cyc(3);
        pulse_load();
        expect_code("R5", 16'h1234);

        // R10: data moves under a held strobe; last value kept.
        tag = "R10"; sel_lo_n = 0; wr_n = 0;
        din = 16'h0011; cyc(1);
        din = 16'h0022; cyc(1);
        din = 16'h0033; cyc(1);
        wr_n = 1; sel_lo_n = 1; din = 16'h0044; cyc(3);
        pulse_load();
        expect_code("R10", 16'h1233);

        // R6, R9, R11: load held low, one-cycle write, four-edge latency.
        tag = "R6"; load_n = 0; cyc(3);
        din = 16'hBEEF; sel_hi_n = 0; sel_lo_n = 0; wr_n = 0;
        tag = "R9"; cyc(1);
        wr_n = 1; sel_hi_n = 1; sel_lo_n = 1;
        cyc(2);
        expect_code("R9", 16'h1233);
        cyc(1);
        expect_code("R9", 16'hBEEF);
        vectors++;
        if (code_upd !== 1'b1) begin
            miscompares++; $display("FAIL R11: code_upd=%b expected 1", code_upd);
        end
        tag = "R11"; cyc(1);
        vectors++;
        if (code_upd !== 1'b0) begin
            miscompares++; $display("FAIL R11: code_upd=%b expected 0", code_upd);
        end

        // R8: clear while load is low and a write is active.
        tag = "R8"; din = 16'h7777; sel_hi_n = 0; sel_lo_n = 0; wr_n = 0; cyc(1);
        clr_n = 0; m_lo = 0; m_hi = 0; m_out = 0; m_clr_cnt = 0;
        #1;
        expect_code("R8", 16'h0000);
        @(negedge clk);
        cyc(2);
        clr_n = 1; cyc(2);
        expect_code("R8", 16'h0000);
        cyc(3);
        expect_code("R8", 16'h7777);
        wr_n = 1; sel_hi_n = 1; sel_lo_n = 1; load_n = 1; cyc(4);

        // R1 again: reset from a nonzero code.
        tag = "R1"; rst_n = 0; cyc(1);
        expect_code("R1", 16'h0000);
        rst_n = 1; cyc(3);

        finish_run();
    end
endmodule